// File: doc/BRIEF.md
# Two-Channel DMA Transfer Engine

This block moves data items from a source address to a destination address on behalf of two independent channels that share one memory port. Each channel holds its own settings: items per block, number of blocks, item width, whether each address steps or stays put, which values reload when a transfer ends, and whether the channel stays armed afterwards. A channel is armed by software and started either by a software trigger pulse or by a hardware request pulse.

Every item is one read from the source followed by one write of the same data to the destination, over a request/acknowledge port that can answer with an error. A small arbiter chooses which busy channel gets the port at each item boundary, under a fixed or an alternating policy chosen by one global input. Each channel reports a 3-bit status code and drives level completion and error interrupts, each gated by its own enable. Channel settings arrive as plain input ports.

Top module: `dma2_engine`

## Requirements
- R1: With `rr_mode` low, whenever both channels are waiting at an item boundary, channel 0 is granted the port.
- R2: With `rr_mode` high, whenever both channels are waiting, the channel not granted most recently is granted, so items of the two channels alternate.
- R3: The width code is 0 for 8-bit, 1 for 16-bit and 2 for 32-bit items and is driven on `mem_size`; after each item an address steps by 1, 2 or 4 bytes unless its fixed bit is set, in which case it does not change.
- R4: In block mode (`cfg_burst` low) one trigger moves exactly one block of `cfg_blk` items (code 0 means 16 items) and the channel then waits; the transfer completes after `cfg_tc` blocks (code 0 means 65536).
- R5: In burst mode (`cfg_burst` high) one trigger moves all `cfg_blk` x `cfg_tc` items of the transfer.
- R6: On completion the status becomes 5; in one-shot mode (`cfg_cont` low) the channel enable clears, in continuous mode it stays set and the next trigger starts a new transfer.
- R7: At completion the block count reloads when `cfg_cnt_rld` is set, the source address reloads when `cfg_src_rld` is set and the destination address reloads when `cfg_dst_rld` is set, each independently; a value that does not reload continues from where it stopped.
- R8: While `glb_pause` or the channel's `ch_pause` is high, the channel starts no new item and its status reads 7; on release it resumes from the next item with its addresses and counts intact.
- R9: Dropping `glb_en`, or pulsing `en_clr`, while a channel is busy stops that channel with status 2 and no further items.
- R10: An error answer on a read sets status 3, on a write sets status 4; the channel stops at once, its enable clears, and no write follows a failed read.
- R11: If an incrementing address has stepped past 0xFFFFFFFF, the channel stops with status 1 before issuing the next item's accesses.
- R12: `irq_done` is high while status is 5 and `done_ie` is set; `irq_err` is high while status is 1, 3 or 4 and `err_ie` is set; a `stat_clr` pulse returns status to 0. After reset all status codes, enables, interrupts and `mem_req` are 0.
- R13: A hardware request arriving while its channel is busy is remembered once and starts the next block or transfer when the channel can accept it; it is discarded if the enable clears, including at one-shot completion.
- R14: Each item is a read of the source followed by a write whose data equals the read data; the request, address and direction stay stable until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global enable; low halts all busy channels |
| glb_pause | input | 1 | Pause all channels |
| rr_mode | input | 1 | 1 alternating arbitration, 0 channel 0 first |
| en_set | input | 2 | Per-channel arm pulse; loads addresses and counts when disarmed |
| en_clr | input | 2 | Per-channel disarm pulse |
| sw_trig | input | 2 | Per-channel software trigger pulse |
| hw_req | input | 2 | Per-channel hardware request pulse |
| ch_pause | input | 2 | Per-channel pause |
| stat_clr | input | 2 | Per-channel status clear pulse |
| done_ie | input | 2 | Completion interrupt enables |
| err_ie | input | 2 | Error interrupt enables |
| cfg_burst | input | 2 | 1 burst mode, 0 block mode |
| cfg_cont | input | 2 | 1 continuous, 0 one-shot |
| cfg_src_fix | input | 2 | Source address held fixed |
| cfg_dst_fix | input | 2 | Destination address held fixed |
| cfg_cnt_rld | input | 2 | Block count reload at completion |
| cfg_src_rld | input | 2 | Source address reload at completion |
| cfg_dst_rld | input | 2 | Destination address reload at completion |
| cfg_width | input | 4 | Width code, 2 bits per channel |
| cfg_blk | input | 8 | Items per block, 4 bits per channel |
| cfg_tc | input | 32 | Blocks per transfer, 16 bits per channel |
| cfg_src | input | 64 | Source start address, 32 bits per channel |
| cfg_dst | input | 64 | Destination start address, 32 bits per channel |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Access byte address |
| mem_size | output | 2 | Access width code |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_ack | input | 1 | Access acknowledge |
| mem_err | input | 1 | Error answer, valid with `mem_ack` |
| ch_status | output | 6 | Status code, 3 bits per channel |
| ch_enabled | output | 2 | Channel enable state |
| irq_done | output | 2 | Completion interrupts |
| irq_err | output | 2 | Error interrupts |

## Verification
The bench drives both channels into the port together under each policy and checks the order of the resulting writes, since an arbiter that ignores its last grant, or regrants mid-item, shows up as two same-channel writes in a row or a torn read/write pair. It pauses a channel right at an item boundary and checks that nothing moves and that the next write lands at the following address, which catches a design that drops or repeats an item on resume. It places a read error and a write error on the second item, and an incrementing source just below the top of the address space, to show that a design issuing the wrapped access or the write after a failed read is caught by the write log. Reload bits are set in mixed combinations, and back-to-back hardware requests are sent in continuous and one-shot modes, exposing a pending request that is lost or survives disarming.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

  localparam int NCH = 2;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_OVF    = 3'd1,
    ST_HALT   = 3'd2,
    ST_SRCERR = 3'd3,
    ST_DSTERR = 3'd4,
    ST_DONE   = 3'd5,
    ST_PAUSE  = 3'd7
  } stat_e;

  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_RD   = 2'd1,
    M_WR   = 2'd2
  } mst_e;

  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd0:    width_bytes = 3'd1;
      2'd1:    width_bytes = 3'd2;
      default: width_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma2_arb.sv
module dma2_arb
  import dma2_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rr_mode,
  input  logic [NCH-1:0] req,
  input  logic           take,
  output logic [NCH-1:0] gnt
);

  logic last_q;

  always_comb begin
    if (req == 2'b11) gnt = (rr_mode && !last_q) ? 2'b10 : 2'b01;
    else              gnt = req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= 1'b1;
    else if (take) last_q <= gnt[1];
  end

  // R1 R2: never more than one grant
  a_r1_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R2: under alternation a contested grant never repeats the last winner
  a_r2_rr_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_mode && take && req == 2'b11) |=> (last_q != $past(last_q)));

endmodule

// File: rtl/dma2_chan.sv
module dma2_chan
  import dma2_pkg::*;
#(
  parameter int AW  = 32,
  parameter int BSW = 4,
  parameter int TCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           glb_en,
  input  logic           paused,
  input  logic           en_set,
  input  logic           en_clr,
  input  logic           sw_trig,
  input  logic           hw_req,
  input  logic           stat_clr,
  input  logic           done_ie,
  input  logic           err_ie,
  input  logic           cfg_burst,
  input  logic           cfg_cont,
  input  logic           cfg_src_fix,
  input  logic           cfg_dst_fix,
  input  logic           cfg_cnt_rld,
  input  logic           cfg_src_rld,
  input  logic           cfg_dst_rld,
  input  logic [1:0]     cfg_width,
  input  logic [BSW-1:0] cfg_blk,
  input  logic [TCW-1:0] cfg_tc,
  input  logic [AW-1:0]  cfg_src,
  input  logic [AW-1:0]  cfg_dst,
  input  logic           ev_ok,
  input  logic           ev_err,
  input  stat_e          ev_code,
  output logic           want,
  output logic           busy,
  output logic           en,
  output logic           wrapped,
  output logic [AW-1:0]  src,
  output logic [AW-1:0]  dst,
  output logic [2:0]     st_out,
  output logic           irq_done,
  output logic           irq_err
);

  logic           en_q, en_d, busy_q, busy_d, pend_q, pend_d;
  logic           sovf_q, sovf_d, dovf_q, dovf_d;
  logic [AW-1:0]  src_q, src_d, dst_q, dst_d;
  logic [BSW-1:0] blk_q, blk_d;
  logic [TCW-1:0] tc_q, tc_d;
  stat_e          st_q, st_d;
  logic [AW:0]    src_nx, dst_nx;
  logic [2:0]     nb;
  logic           trig, last_item, last_blk;

  assign nb        = width_bytes(cfg_width);
  assign src_nx    = {1'b0, src_q} + {{(AW-2){1'b0}}, nb};
  assign dst_nx    = {1'b0, dst_q} + {{(AW-2){1'b0}}, nb};
  assign trig      = sw_trig | hw_req | pend_q;
  assign last_item = (blk_q == BSW'(1));
  assign last_blk  = (tc_q == TCW'(1));

  always_comb begin
    en_d = en_q;  busy_d = busy_q;  pend_d = pend_q;
    src_d = src_q;  dst_d = dst_q;  sovf_d = sovf_q;  dovf_d = dovf_q;
    blk_d = blk_q;  tc_d = tc_q;  st_d = st_q;
    if (stat_clr) st_d = ST_IDLE;
    if (en_q && busy_q && (en_clr || !glb_en)) begin
      busy_d = 1'b0;  pend_d = 1'b0;  st_d = ST_HALT;
      en_d   = ~en_clr;
    end else if (en_q && en_clr) begin
      en_d = 1'b0;  pend_d = 1'b0;
    end else if (!en_q) begin
      pend_d = 1'b0;
      if (en_set) begin
        en_d = 1'b1;  src_d = cfg_src;  dst_d = cfg_dst;  tc_d = cfg_tc;
        sovf_d = 1'b0;  dovf_d = 1'b0;
      end
    end else if (busy_q && ev_err) begin
      busy_d = 1'b0;  en_d = 1'b0;  pend_d = 1'b0;  st_d = ev_code;
    end else if (busy_q && ev_ok) begin
      if (!cfg_src_fix) begin src_d = src_nx[AW-1:0]; sovf_d = src_nx[AW]; end
      if (!cfg_dst_fix) begin dst_d = dst_nx[AW-1:0]; dovf_d = dst_nx[AW]; end
      blk_d = blk_q - BSW'(1);
      if (hw_req) pend_d = 1'b1;
      if (last_item) begin
        tc_d = tc_q - TCW'(1);
        if (last_blk) begin
          busy_d = 1'b0;  st_d = ST_DONE;
          if (!cfg_cont)   begin en_d = 1'b0; pend_d = 1'b0; end
          if (cfg_cnt_rld) tc_d = cfg_tc;
          if (cfg_src_rld) begin src_d = cfg_src; sovf_d = 1'b0; end
          if (cfg_dst_rld) begin dst_d = cfg_dst; dovf_d = 1'b0; end
        end else if (cfg_burst) begin
          blk_d = cfg_blk;
        end else begin
          busy_d = 1'b0;
        end
      end
    end else if (!busy_q && glb_en && trig) begin
      busy_d = 1'b1;  blk_d = cfg_blk;  pend_d = 1'b0;
    end else if (busy_q && hw_req) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;  busy_q <= 1'b0;  pend_q <= 1'b0;
      sovf_q <= 1'b0;  dovf_q <= 1'b0;
      src_q <= '0;  dst_q <= '0;  blk_q <= '0;  tc_q <= '0;
      st_q <= ST_IDLE;
    end else begin
      en_q <= en_d;  busy_q <= busy_d;  pend_q <= pend_d;
      sovf_q <= sovf_d;  dovf_q <= dovf_d;
      src_q <= src_d;  dst_q <= dst_d;  blk_q <= blk_d;  tc_q <= tc_d;
      st_q <= st_d;
    end
  end

  assign want     = busy_q & ~paused & glb_en;
  assign busy     = busy_q;
  assign en       = en_q;
  assign wrapped  = sovf_q | dovf_q;
  assign src      = src_q;
  assign dst      = dst_q;
  assign st_out   = (busy_q && paused) ? ST_PAUSE : st_q;
  assign irq_done = done_ie & (st_q == ST_DONE);
  assign irq_err  = err_ie & ((st_q == ST_OVF) | (st_q == ST_SRCERR) | (st_q == ST_DSTERR));

  // R10: an error answer disarms the channel
  a_r10_err_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && busy_q && ev_err && !en_clr && glb_en) |=> !en_q);

  // R6: the last item of a one-shot transfer disarms and reports completion
  a_r6_oneshot_done: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && busy_q && ev_ok && !ev_err && last_item && last_blk && !cfg_cont && !en_clr && glb_en)
    |=> (!en_q && st_q == ST_DONE));

  // R9: halting a busy channel leaves it idle with the halt code
  a_r9_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && busy_q && !glb_en) |=> (!busy_q && st_q == ST_HALT));

endmodule

// File: rtl/dma2_engine.sv
module dma2_engine
  import dma2_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int BSW = 4,
  parameter int TCW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_en,
  input  logic             glb_pause,
  input  logic             rr_mode,
  input  logic [1:0]       en_set,
  input  logic [1:0]       en_clr,
  input  logic [1:0]       sw_trig,
  input  logic [1:0]       hw_req,
  input  logic [1:0]       ch_pause,
  input  logic [1:0]       stat_clr,
  input  logic [1:0]       done_ie,
  input  logic [1:0]       err_ie,
  input  logic [1:0]       cfg_burst,
  input  logic [1:0]       cfg_cont,
  input  logic [1:0]       cfg_src_fix,
  input  logic [1:0]       cfg_dst_fix,
  input  logic [1:0]       cfg_cnt_rld,
  input  logic [1:0]       cfg_src_rld,
  input  logic [1:0]       cfg_dst_rld,
  input  logic [2*2-1:0]   cfg_width,
  input  logic [2*BSW-1:0] cfg_blk,
  input  logic [2*TCW-1:0] cfg_tc,
  input  logic [2*AW-1:0]  cfg_src,
  input  logic [2*AW-1:0]  cfg_dst,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [1:0]       mem_size,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ack,
  input  logic             mem_err,
  output logic [2*3-1:0]   ch_status,
  output logic [1:0]       ch_enabled,
  output logic [1:0]       irq_done,
  output logic [1:0]       irq_err
);

  logic [NCH-1:0] want, busy_w, wrap_w, gnt, ev_ok, ev_err;
  logic [AW-1:0]  src_w [NCH];
  logic [AW-1:0]  dst_w [NCH];
  stat_e          ev_code;
  mst_e           m_q, m_d;
  logic           sel_q, sel_d, take, gidx;
  logic [DW-1:0]  buf_q, buf_d;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma2_chan #(.AW(AW), .BSW(BSW), .TCW(TCW)) u_ch (
      .clk(clk), .rst_n(rst_n), .glb_en(glb_en),
      .paused(glb_pause | ch_pause[i]),
      .en_set(en_set[i]), .en_clr(en_clr[i]), .sw_trig(sw_trig[i]),
      .hw_req(hw_req[i]), .stat_clr(stat_clr[i]),
      .done_ie(done_ie[i]), .err_ie(err_ie[i]),
      .cfg_burst(cfg_burst[i]), .cfg_cont(cfg_cont[i]),
      .cfg_src_fix(cfg_src_fix[i]), .cfg_dst_fix(cfg_dst_fix[i]),
      .cfg_cnt_rld(cfg_cnt_rld[i]), .cfg_src_rld(cfg_src_rld[i]),
      .cfg_dst_rld(cfg_dst_rld[i]),
      .cfg_width(cfg_width[i*2 +: 2]), .cfg_blk(cfg_blk[i*BSW +: BSW]),
      .cfg_tc(cfg_tc[i*TCW +: TCW]), .cfg_src(cfg_src[i*AW +: AW]),
      .cfg_dst(cfg_dst[i*AW +: AW]),
      .ev_ok(ev_ok[i]), .ev_err(ev_err[i]), .ev_code(ev_code),
      .want(want[i]), .busy(busy_w[i]), .en(ch_enabled[i]), .wrapped(wrap_w[i]),
      .src(src_w[i]), .dst(dst_w[i]), .st_out(ch_status[i*3 +: 3]),
      .irq_done(irq_done[i]), .irq_err(irq_err[i])
    );
  end

  dma2_arb u_arb (
    .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode),
    .req(want), .take(take), .gnt(gnt)
  );

  assign take = (m_q == M_IDLE) && (|gnt);
  assign gidx = gnt[1];

  always_comb begin
    m_d = m_q;  sel_d = sel_q;  buf_d = buf_q;
    ev_ok = '0;  ev_err = '0;  ev_code = ST_IDLE;
    case (m_q)
      M_IDLE: if (take) begin
        sel_d = gidx;
        if (wrap_w[gidx]) begin
          ev_err[gidx] = 1'b1;  ev_code = ST_OVF;
        end else begin
          m_d = M_RD;
        end
      end
      M_RD: if (mem_ack) begin
        if (mem_err) begin
          ev_err[sel_q] = 1'b1;  ev_code = ST_SRCERR;  m_d = M_IDLE;
        end else if (!busy_w[sel_q]) begin
          m_d = M_IDLE;
        end else begin
          buf_d = mem_rdata;  m_d = M_WR;
        end
      end
      M_WR: if (mem_ack) begin
        m_d = M_IDLE;
        if (mem_err) begin
          ev_err[sel_q] = 1'b1;  ev_code = ST_DSTERR;
        end else begin
          ev_ok[sel_q] = 1'b1;
        end
      end
      default: m_d = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= M_IDLE;  sel_q <= 1'b0;  buf_q <= '0;
    end else begin
      m_q <= m_d;  sel_q <= sel_d;  buf_q <= buf_d;
    end
  end

  assign mem_req   = (m_q != M_IDLE);
  assign mem_we    = (m_q == M_WR);
  assign mem_addr  = (m_q == M_WR) ? dst_w[sel_q] : src_w[sel_q];
  assign mem_size  = cfg_width[{sel_q, 1'b0} +: 2];
  assign mem_wdata = buf_q;

  // R14: an outstanding access holds address and direction until acknowledged
  a_r14_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R14: a write is always preceded by a read in the previous cycle or held
  a_r14_rd_before_wr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> ($past(mem_req) && !$past(mem_we)));

  // R8: global pause keeps an idle port idle
  a_r8_pause_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_pause && !mem_req) |=> !mem_req);

  // R11: a wrapped channel is aborted without issuing an access
  a_r11_ovf_noaccess: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wrap_w[gidx]) |=> !mem_req);

endmodule

// File: tb/dma2_engine_tb.sv
module dma2_engine_tb;

  localparam logic [31:0] KEY = 32'h5A5A_0000;

  logic        clk, rst_n;
  logic        glb_en, glb_pause, rr_mode;
  logic [1:0]  en_set, en_clr, sw_trig, hw_req, ch_pause, stat_clr, done_ie, err_ie;
  logic [1:0]  cfg_burst, cfg_cont, cfg_src_fix, cfg_dst_fix, cfg_cnt_rld, cfg_src_rld, cfg_dst_rld;
  logic [3:0]  cfg_width;
  logic [7:0]  cfg_blk;
  logic [31:0] cfg_tc;
  logic [63:0] cfg_src, cfg_dst;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic [5:0]  ch_status;
  logic [1:0]  ch_enabled, irq_done, irq_err;

  logic        err_arm, err_we;
  logic [31:0] err_addr;
  logic [31:0] w_addr [0:255];
  logic [31:0] w_data [0:255];
  logic [1:0]  w_size [0:255];
  logic [31:0] r_addr [0:255];
  int          w_n, r_n;
  int          n_chk, n_fail;
  bit          ended;

  dma2_engine u_dut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .glb_pause(glb_pause), .rr_mode(rr_mode),
    .en_set(en_set), .en_clr(en_clr), .sw_trig(sw_trig), .hw_req(hw_req),
    .ch_pause(ch_pause), .stat_clr(stat_clr), .done_ie(done_ie), .err_ie(err_ie),
    .cfg_burst(cfg_burst), .cfg_cont(cfg_cont), .cfg_src_fix(cfg_src_fix),
    .cfg_dst_fix(cfg_dst_fix), .cfg_cnt_rld(cfg_cnt_rld), .cfg_src_rld(cfg_src_rld),
    .cfg_dst_rld(cfg_dst_rld), .cfg_width(cfg_width), .cfg_blk(cfg_blk), .cfg_tc(cfg_tc),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .ch_status(ch_status), .ch_enabled(ch_enabled), .irq_done(irq_done), .irq_err(irq_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign mem_rdata = mem_addr ^ KEY;

  // memory model: one-cycle acknowledge, optional error on one address
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end else begin
      if (mem_req && mem_ack && !mem_err) begin
        if (mem_we) begin
          if (w_n < 256) begin
            w_addr[w_n] = mem_addr; w_data[w_n] = mem_wdata; w_size[w_n] = mem_size;
          end
          w_n = w_n + 1;
        end else begin
          if (r_n < 256) r_addr[r_n] = mem_addr;
          r_n = r_n + 1;
        end
      end
      mem_ack <= mem_req && !mem_ack;
      mem_err <= mem_req && !mem_ack && err_arm && (mem_addr == err_addr) && (mem_we == err_we);
    end
  end

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_writes(int n);
    for (int t = 0; t < 3000 && w_n < n; t++) @(negedge clk);
  endtask

  task automatic clr_log();
    w_n = 0;
    r_n = 0;
  endtask

  function automatic logic [2:0] st(int ch);
    return ch_status[ch*3 +: 3];
  endfunction

  task automatic cfg_ch(int ch, bit burst, logic [1:0] w, logic [3:0] blk, logic [15:0] tc,
                        logic [31:0] s, logic [31:0] d, bit sfix, bit dfix,
                        bit crld, bit srld, bit drld, bit cont);
    cfg_burst[ch] = burst;  cfg_width[ch*2 +: 2] = w;  cfg_blk[ch*4 +: 4] = blk;
    cfg_tc[ch*16 +: 16] = tc;  cfg_src[ch*32 +: 32] = s;  cfg_dst[ch*32 +: 32] = d;
    cfg_src_fix[ch] = sfix;  cfg_dst_fix[ch] = dfix;  cfg_cnt_rld[ch] = crld;
    cfg_src_rld[ch] = srld;  cfg_dst_rld[ch] = drld;  cfg_cont[ch] = cont;
  endtask

  task automatic arm(int ch);
    en_clr[ch] = 1'b1; tick(1); en_clr[ch] = 1'b0;
    en_set[ch] = 1'b1; tick(1); en_set[ch] = 1'b0;
  endtask

  task automatic swt(logic [1:0] m);
    sw_trig = m; tick(1); sw_trig = 2'b00;
  endtask

  task automatic hwp(int ch);
    hw_req[ch] = 1'b1; tick(1); hw_req[ch] = 1'b0;
  endtask

  task automatic sclr(int ch);
    stat_clr[ch] = 1'b1; tick(1); stat_clr[ch] = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12", "reset status", ch_status, 0);
    chk("R12", "reset enables", ch_enabled, 0);
    chk("R12", "reset irq", {irq_done, irq_err}, 0);
    chk("R12", "reset mem_req", mem_req, 0);
  endtask

  task automatic t_block();
    done_ie[0] = 1'b1;
    cfg_ch(0, 0, 2'd2, 4'd3, 16'd2, 32'h100, 32'h1000, 0, 0, 0, 0, 0, 0);
    clr_log(); arm(0); swt(2'b01);
    wait_writes(3); tick(40);
    chk("R4", "one block per trigger", w_n, 3);
    chk("R4", "status mid transfer", st(0), 0);
    chk("R14", "write data equals read data", w_data[0], 32'h100 ^ KEY);
    chk("R3", "32-bit dst step", w_addr[2], 32'h1008);
    chk("R3", "32-bit src step", r_addr[1], 32'h104);
    chk("R3", "size code", w_size[0], 2);
    swt(2'b01); wait_writes(6); tick(20);
    chk("R4", "second block", w_n, 6);
    chk("R4", "last dst", w_addr[5], 32'h1014);
    chk("R6", "done status", st(0), 5);
    chk("R6", "one-shot disarm", ch_enabled[0], 0);
    chk("R12", "irq_done", irq_done[0], 1);
    sclr(0); tick(1);
    chk("R12", "status cleared", st(0), 0);
    chk("R12", "irq_done cleared", irq_done[0], 0);
  endtask

  task automatic t_blk16();
    cfg_ch(0, 0, 2'd0, 4'd0, 16'd1, 32'h200, 32'h1100, 0, 0, 0, 0, 0, 0);
    clr_log(); arm(0); swt(2'b01);
    wait_writes(16); tick(30);
    chk("R4", "block code 0 moves 16", w_n, 16);
    chk("R3", "byte step", w_addr[15], 32'h110F);
    chk("R3", "byte size code", w_size[15], 0);
  endtask

  task automatic t_burst();
    cfg_ch(1, 1, 2'd1, 4'd2, 16'd3, 32'h300, 32'h2000, 1, 0, 0, 0, 0, 0);
    clr_log(); arm(1); swt(2'b10);
    wait_writes(6); tick(30);
    chk("R5", "burst moves all items", w_n, 6);
    chk("R3", "fixed src", r_addr[5], 32'h300);
    chk("R3", "16-bit dst step", w_addr[5], 32'h200A);
    chk("R5", "burst done", st(1), 5);
  endtask

  task automatic t_prio();
    rr_mode = 1'b0;
    cfg_ch(0, 1, 2'd2, 4'd2, 16'd1, 32'h400, 32'h1000, 0, 0, 0, 0, 0, 0);
    cfg_ch(1, 1, 2'd2, 4'd2, 16'd1, 32'h500, 32'h2000, 0, 0, 0, 0, 0, 0);
    clr_log(); arm(0); arm(1); swt(2'b11);
    wait_writes(4); tick(20);
    chk("R1", "first write ch0", w_addr[0], 32'h1000);
    chk("R1", "second write ch0", w_addr[1], 32'h1004);
    chk("R1", "third write ch1", w_addr[2], 32'h2000);
  endtask

  task automatic t_rr();
    rr_mode = 1'b1;
    cfg_ch(0, 1, 2'd2, 4'd3, 16'd1, 32'h400, 32'h1000, 0, 0, 0, 0, 0, 0);
    cfg_ch(1, 1, 2'd2, 4'd3, 16'd1, 32'h500, 32'h2000, 0, 0, 0, 0, 0, 0);
    clr_log(); arm(0); arm(1); swt(2'b11);
    wait_writes(6); tick(20);
    chk("R2", "total", w_n, 6);
    chk("R2", "alternate 0-1", w_addr[0][13:12] != w_addr[1][13:12], 1);
    chk("R2", "alternate 1-2", w_addr[1][13:12] != w_addr[2][13:12], 1);
    chk("R2", "alternate 4-5", w_addr[4][13:12] != w_addr[5][13:12], 1);
    rr_mode = 1'b0;
  endtask

  task automatic t_pause();
    cfg_ch(0, 1, 2'd0, 4'd4, 16'd1, 32'h600, 32'h1200, 0, 0, 0, 0, 0, 0);
    clr_log(); arm(0); swt(2'b01);
    wait_writes(1);
    ch_pause[0] = 1'b1;
    tick(20);
    chk("R8", "no item while paused", w_n, 1);
    chk("R8", "paused status", st(0), 7);
    ch_pause[0] = 1'b0;
    wait_writes(4); tick(20);
    chk("R8", "resumed count", w_n, 4);
    chk("R8", "resume at next item", w_addr[1], 32'h1201);
    glb_pause = 1'b1;
    arm(0); clr_log(); swt(2'b01); tick(20);
    chk("R8", "global pause holds", w_n, 0);
    glb_pause = 1'b0;
    wait_writes(4); tick(20);
    chk("R8", "global resume", w_n, 4);
  endtask

  task automatic t_halt();
    cfg_ch(1, 1, 2'd2, 4'd8, 16'd1, 32'h700, 32'h2100, 0, 0, 0, 0, 0, 0);
    clr_log(); arm(1); swt(2'b10);
    wait_writes(2);
    glb_en = 1'b0;
    tick(20);
    chk("R9", "halt status", st(1), 2);
    chk("R9", "no items after halt", w_n, 2);
    glb_en = 1'b1;
    tick(20);
    chk("R9", "stays stopped", w_n, 2);
  endtask

  task automatic t_errors();
    err_ie[0] = 1'b1;
    cfg_ch(0, 1, 2'd2, 4'd4, 16'd1, 32'h800, 32'h1300, 0, 0, 0, 0, 0, 0);
    err_arm = 1'b1; err_addr = 32'h804; err_we = 1'b0;
    clr_log(); arm(0); swt(2'b01); tick(40);
    chk("R10", "read error status", st(0), 3);
    chk("R10", "no write after bad read", w_n, 1);
    chk("R10", "disarmed", ch_enabled[0], 0);
    chk("R12", "irq_err", irq_err[0], 1);
    sclr(0); tick(1);
    chk("R12", "irq_err cleared", irq_err[0], 0);
    err_addr = 32'h1304; err_we = 1'b1;
    clr_log(); arm(0); swt(2'b01); tick(40);
    chk("R10", "write error status", st(0), 4);
    chk("R10", "reads before write error", r_n, 2);
    chk("R10", "writes before error", w_n, 1);
    err_arm = 1'b0;
  endtask

  task automatic t_ovf();
    cfg_ch(1, 1, 2'd2, 4'd4, 16'd1, 32'hFFFF_FFF8, 32'h2200, 0, 0, 0, 0, 0, 0);
    clr_log(); arm(1); swt(2'b10); tick(50);
    chk("R11", "overflow status", st(1), 1);
    chk("R11", "writes before wrap", w_n, 2);
    chk("R11", "no read after wrap", r_n, 2);
  endtask

  task automatic t_reload();
    cfg_ch(1, 0, 2'd2, 4'd2, 16'd1, 32'h900, 32'h2300, 0, 0, 1, 1, 0, 1);
    clr_log(); arm(1); swt(2'b10);
    wait_writes(2); tick(20);
    chk("R6", "continuous done", st(1), 5);
    chk("R6", "continuous stays armed", ch_enabled[1], 1);
    sclr(1);
    swt(2'b10); wait_writes(4); tick(20);
    chk("R7", "count reload completes again", st(1), 5);
    chk("R7", "src reloaded", w_data[2], 32'h900 ^ KEY);
    chk("R7", "dst continues", w_addr[2], 32'h2308);
    chk("R7", "item total", w_n, 4);
  endtask

  task automatic t_pend();
    cfg_ch(0, 0, 2'd2, 4'd2, 16'd1, 32'hA00, 32'h1400, 0, 0, 1, 0, 0, 1);
    clr_log(); arm(0); hwp(0); hwp(0);
    wait_writes(4); tick(30);
    chk("R13", "pending request served", w_n, 4);
    cfg_cont[0] = 1'b0;
    clr_log(); arm(0); hwp(0); hwp(0);
    wait_writes(2); tick(30);
    chk("R13", "pending dropped at one-shot end", w_n, 2);
    arm(0); tick(30);
    chk("R13", "no start after rearm", w_n, 0 + 2);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; ended = 1'b0; w_n = 0; r_n = 0;
    rst_n = 1'b0; glb_en = 1'b1; glb_pause = 1'b0; rr_mode = 1'b0;
    en_set = '0; en_clr = '0; sw_trig = '0; hw_req = '0; ch_pause = '0; stat_clr = '0;
    done_ie = '0; err_ie = '0;
    cfg_burst = '0; cfg_cont = '0; cfg_src_fix = '0; cfg_dst_fix = '0;
    cfg_cnt_rld = '0; cfg_src_rld = '0; cfg_dst_rld = '0;
    cfg_width = '0; cfg_blk = '0; cfg_tc = '0; cfg_src = '0; cfg_dst = '0;
    err_arm = 1'b0; err_we = 1'b0; err_addr = '0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_block();
    t_blk16();
    t_burst();
    t_prio();
    t_rr();
    t_pause();
    t_halt();
    t_errors();
    t_ovf();
    t_reload();
    t_pend();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule